// File: doc/BRIEF.md
# Video Sync Conditioner

This block sits at the front of a video capture path. It receives a pixel clock domain stream of data words with a qualifying valid strobe and turns the timing carried by that stream into four clean active-high outputs: horizontal sync, vertical sync, data enable and field. The pixel word is passed through with the same delay, so downstream logic sees each word alongside its timing.

The block is built in one of two variants, chosen by a parameter. In the embedded variant, timing arrives as reserved code sequences inside the data words. The decoder reads the field, vertical and horizontal flags from each timing code and gates data enable accordingly. Ancillary packets found during blanking are copied to a simple RAM write port. In the discrete variant, separate horizontal sync, vertical sync, enable and field pins are sampled. Two static configuration inputs set whether each sync pin is active low, and active-low pins are inverted. In either variant, an option can replace the field output with one derived from where the vertical sync edge falls within the line.

Top module: `vid_sync_cond`

## Requirements
- R1: Every output is registered with one clock of latency: `out_valid` equals `vid_valid` of the previous cycle and `out_data` equals `vid_data` of the previous cycle.
- R2: A cycle with `vid_valid` low is not processed. On the next cycle `out_valid` and `out_de` are 0, `out_hs`, `out_vs` and `out_f` keep their values, and `anc_we` is 0, whatever the data word carries.
- R3: Embedded variant: a timing code is the valid-word sequence all-ones, all-zeros, all-zeros, flags. In the flags word of a 10-bit stream, bit 8 is field, bit 7 is vertical blanking and bit 6 is horizontal blanking (1 = end of active video). From the cycle after the flags word, `out_hs` shows the horizontal flag and `out_vs` shows the vertical flag. The blanking state after reset is horizontal = 1, vertical = 1.
- R4: Embedded variant: `out_de` is 1 for a valid word only when the latest horizontal and vertical flags are both 0, the word is not a flags word, and the word is neither all-zeros nor all-ones.
- R5: Discrete variant: on valid cycles `out_hs` = `vid_hs` XOR `cfg_hs_low` and `out_vs` = `vid_vs` XOR `cfg_vs_low`, and `out_de` follows `vid_de`.
- R6: With field extraction enabled, on a valid cycle where the normalised vertical sync goes from 0 to 1, `out_f` becomes the normalised horizontal sync of that cycle. Otherwise `out_f` keeps its value.
- R7: With field extraction disabled, `out_f` follows `vid_fld` on valid cycles in the discrete variant, and follows the field flag of the latest timing code in the embedded variant.
- R8: Embedded variant: while the current flags show blanking (horizontal or vertical = 1), the valid-word sequence all-zeros, all-ones, all-ones starts an ancillary packet. The next three words (ID, secondary ID, count) are written, and then as many further words as the low 8 bits of the count word. Each write pulses `anc_we` for one cycle with the word on `anc_wdata` and the next sequential address on `anc_addr`.
- R9: The ancillary write address starts at 0 after reset and wraps from `ANC_DEPTH-1` to 0.
- R10: The ancillary start sequence seen while both flags are 0 (active video) produces no write.
- R11: During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_data | input | DATA_W | Pixel or code word |
| vid_valid | input | 1 | Word qualifier |
| vid_hs | input | 1 | Discrete horizontal sync pin |
| vid_vs | input | 1 | Discrete vertical sync pin |
| vid_de | input | 1 | Discrete data enable pin (active high) |
| vid_fld | input | 1 | Discrete field pin (active high) |
| cfg_hs_low | input | 1 | Static: horizontal sync pin is active low |
| cfg_vs_low | input | 1 | Static: vertical sync pin is active low |
| out_data | output | DATA_W | Delayed pixel word |
| out_valid | output | 1 | Delayed qualifier |
| out_hs | output | 1 | Active-high horizontal sync |
| out_vs | output | 1 | Active-high vertical sync |
| out_de | output | 1 | Data enable |
| out_f | output | 1 | Field flag |
| anc_we | output | 1 | Ancillary RAM write enable |
| anc_addr | output | ANC_AW | Ancillary RAM write address |
| anc_wdata | output | DATA_W | Ancillary RAM write data |

## Verification
The embedded decoder is driven with whole lines: end and start codes around random non-reserved pixels, vertical-blanking lines, and both field values. Random idle cycles are spread through the stream and carry code-like words, which shows whether unqualified words are ignored. The lines also carry ancillary packets of assorted lengths, including a zero count, enough in total to wrap the address, plus a start sequence placed inside active video. This separates packet capture in blanking from capture in active video and tests the header and count handling. The discrete variants get random sync levels under all four polarity settings. This gives rising vertical edges with the horizontal sync both high and low, which separates edge-derived field from pin-derived field.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
   typedef enum logic [1:0] {
      ANC_IDLE = 2'd0,
      ANC_HDR  = 2'd1,
      ANC_BODY = 2'd2
   } anc_state_t;

   localparam int ANC_HDR_WORDS = 3;
   localparam int ANC_CNT_W     = 8;
endpackage

// File: rtl/vsc_trs_decode.sv
module vsc_trs_decode #(
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic [DATA_W-1:0] word,
   output logic              nxt_h,
   output logic              nxt_v,
   output logic              nxt_f,
   output logic              nxt_de,
   output logic              blank
);
   localparam int F_BIT = DATA_W - 2;
   localparam int V_BIT = DATA_W - 3;
   localparam int H_BIT = DATA_W - 4;

   if (DATA_W < 8) begin : g_chk_w
      $error("vsc_trs_decode: DATA_W must be at least 8");
   end

   logic [DATA_W-1:0] hist1, hist2, hist3;
   logic              h_q, v_q, f_q;
   logic              flags_word, reserved;

   always_comb begin
      flags_word = (hist3 == '1) && (hist2 == '0) && (hist1 == '0);
      reserved   = (word == '1) || (word == '0);
      nxt_h      = flags_word ? word[H_BIT] : h_q;
      nxt_v      = flags_word ? word[V_BIT] : v_q;
      nxt_f      = flags_word ? word[F_BIT] : f_q;
      nxt_de     = !flags_word && !reserved && !nxt_h && !nxt_v;
   end

   assign blank = h_q | v_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist1 <= '0;
         hist2 <= '0;
         hist3 <= '0;
         h_q   <= 1'b1;
         v_q   <= 1'b1;
         f_q   <= 1'b0;
      end else if (valid) begin
         hist3 <= hist2;
         hist2 <= hist1;
         hist1 <= word;
         h_q   <= nxt_h;
         v_q   <= nxt_v;
         f_q   <= nxt_f;
      end
   end

   // R3: flags held between valid words
   a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> ($stable(h_q) && $stable(v_q) && $stable(f_q)));
endmodule

// File: rtl/vsc_sep_sync.sv
module vsc_sep_sync (
   input  logic hs_in,
   input  logic vs_in,
   input  logic de_in,
   input  logic fld_in,
   input  logic hs_low,
   input  logic vs_low,
   output logic hs,
   output logic vs,
   output logic de,
   output logic fld
);
   always_comb begin
      hs  = hs_in ^ hs_low;
      vs  = vs_in ^ vs_low;
      de  = de_in;
      fld = fld_in;
   end
endmodule

// File: rtl/vsc_field_gen.sv
module vsc_field_gen #(
   parameter bit EXTRACT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic valid,
   input  logic hs,
   input  logic vs,
   input  logic f_in,
   output logic f_out
);
   if (EXTRACT) begin : g_edge
      logic vs_prev;
      logic unused_fin;
      assign unused_fin = f_in;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vs_prev <= 1'b0;
            f_out   <= 1'b0;
         end else if (valid) begin
            vs_prev <= vs;
            if (vs && !vs_prev) f_out <= hs;
         end
      end

      // R6: field taken from horizontal sync at the vertical rising edge
      a_r6_edge_field: assert property (@(posedge clk) disable iff (!rst_n)
         (valid && vs && !vs_prev) |=> (f_out == $past(hs)));
      a_r6_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !(valid && vs && !vs_prev) |=> $stable(f_out));
   end else begin : g_pin
      logic unused_sync;
      assign unused_sync = hs ^ vs;

      always_ff @(posedge clk) begin
         if (!rst_n)     f_out <= 1'b0;
         else if (valid) f_out <= f_in;
      end

      // R7: field follows its source on valid words
      a_r7_field_follow: assert property (@(posedge clk) disable iff (!rst_n)
         valid |=> (f_out == $past(f_in)));
   end
endmodule

// File: rtl/vsc_anc_extract.sv
module vsc_anc_extract
   import vsc_pkg::*;
#(
   parameter  int DATA_W = 10,
   parameter  int DEPTH  = 64,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic [DATA_W-1:0] word,
   input  logic              blank,
   output logic              we,
   output logic [AW-1:0]     addr,
   output logic [DATA_W-1:0] wdata
);
   localparam logic [1:0] LAST_HDR = 2'(ANC_HDR_WORDS - 1);

   if (DEPTH < 2) begin : g_chk_d
      $error("vsc_anc_extract: DEPTH must be at least 2");
   end
   if (DATA_W < ANC_CNT_W) begin : g_chk_w
      $error("vsc_anc_extract: DATA_W too narrow for the count field");
   end

   logic [DATA_W-1:0]    prev0, prev1;
   anc_state_t           st;
   logic [1:0]           hdr_cnt;
   logic [ANC_CNT_W-1:0] remain;
   logic [AW-1:0]        ptr, ptr_next;
   logic                 start_hit;

   assign ptr_next  = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
   assign start_hit = blank && (word == '1) && (prev0 == '1) && (prev1 == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev0   <= '0;
         prev1   <= '0;
         st      <= ANC_IDLE;
         hdr_cnt <= '0;
         remain  <= '0;
         ptr     <= '0;
         we      <= 1'b0;
         addr    <= '0;
         wdata   <= '0;
      end else begin
         we <= 1'b0;
         if (valid) begin
            prev1 <= prev0;
            prev0 <= word;
            unique case (st)
               ANC_IDLE: begin
                  if (start_hit) begin
                     st      <= ANC_HDR;
                     hdr_cnt <= '0;
                  end
               end
               ANC_HDR: begin
                  we      <= 1'b1;
                  addr    <= ptr;
                  wdata   <= word;
                  ptr     <= ptr_next;
                  hdr_cnt <= hdr_cnt + 1'b1;
                  if (hdr_cnt == LAST_HDR) begin
                     remain <= word[ANC_CNT_W-1:0];
                     st     <= (word[ANC_CNT_W-1:0] == '0) ? ANC_IDLE : ANC_BODY;
                  end
               end
               ANC_BODY: begin
                  we     <= 1'b1;
                  addr   <= ptr;
                  wdata  <= word;
                  ptr    <= ptr_next;
                  remain <= remain - 1'b1;
                  if (remain == ANC_CNT_W'(1)) st <= ANC_IDLE;
               end
               default: st <= ANC_IDLE;
            endcase
         end
      end
   end

   // R8: a write only ever follows a qualified word
   a_r8_we_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> $past(valid));
   // R8: back-to-back writes use consecutive addresses
   a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (we && $past(we) && ($past(addr) != AW'(DEPTH - 1))) |-> (addr == AW'($past(addr) + 1'b1)));
   // R9: address wraps to zero after the last location
   a_r9_addr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (we && $past(we) && ($past(addr) == AW'(DEPTH - 1))) |-> (addr == '0));
   // R10: no packet starts outside blanking
   a_r10_no_start_active: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !blank && (st == ANC_IDLE)) |=> (st == ANC_IDLE));
endmodule

// File: rtl/vid_sync_cond.sv
module vid_sync_cond #(
   parameter  int DATA_W           = 10,
   parameter  bit EMBEDDED         = 1'b1,
   parameter  bit FIELD_FROM_VSYNC = 1'b0,
   parameter  int ANC_DEPTH        = 64,
   localparam int ANC_AW           = $clog2(ANC_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] vid_data,
   input  logic              vid_valid,
   input  logic              vid_hs,
   input  logic              vid_vs,
   input  logic              vid_de,
   input  logic              vid_fld,
   input  logic              cfg_hs_low,
   input  logic              cfg_vs_low,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   output logic              out_hs,
   output logic              out_vs,
   output logic              out_de,
   output logic              out_f,
   output logic              anc_we,
   output logic [ANC_AW-1:0] anc_addr,
   output logic [DATA_W-1:0] anc_wdata
);
   if (DATA_W < 8) begin : g_chk_w
      $error("vid_sync_cond: DATA_W must be at least 8");
   end
   if (ANC_DEPTH < 2) begin : g_chk_d
      $error("vid_sync_cond: ANC_DEPTH must be at least 2");
   end

   logic nh, nv, nf, nde;

   if (EMBEDDED) begin : g_emb
      logic blank;
      logic unused_pins;
      assign unused_pins = ^{vid_hs, vid_vs, vid_de, vid_fld, cfg_hs_low, cfg_vs_low};

      vsc_trs_decode #(.DATA_W(DATA_W)) u_dec (
         .clk    (clk),
         .rst_n  (rst_n),
         .valid  (vid_valid),
         .word   (vid_data),
         .nxt_h  (nh),
         .nxt_v  (nv),
         .nxt_f  (nf),
         .nxt_de (nde),
         .blank  (blank)
      );

      vsc_anc_extract #(.DATA_W(DATA_W), .DEPTH(ANC_DEPTH)) u_anc (
         .clk   (clk),
         .rst_n (rst_n),
         .valid (vid_valid),
         .word  (vid_data),
         .blank (blank),
         .we    (anc_we),
         .addr  (anc_addr),
         .wdata (anc_wdata)
      );

      // R4: no enable during vertical or horizontal blanking
      a_r4_no_de_blank: assert property (@(posedge clk) disable iff (!rst_n)
         (out_vs || out_hs) |-> !out_de);
   end else begin : g_sep
      vsc_sep_sync u_sep (
         .hs_in  (vid_hs),
         .vs_in  (vid_vs),
         .de_in  (vid_de),
         .fld_in (vid_fld),
         .hs_low (cfg_hs_low),
         .vs_low (cfg_vs_low),
         .hs     (nh),
         .vs     (nv),
         .de     (nde),
         .fld    (nf)
      );

      assign anc_we    = 1'b0;
      assign anc_addr  = '0;
      assign anc_wdata = '0;

      // R5: enable and normalised syncs follow the pins
      a_r5_de_follow: assert property (@(posedge clk) disable iff (!rst_n)
         vid_valid |=> (out_de == $past(vid_de)));
      a_r5_hs_polarity: assert property (@(posedge clk) disable iff (!rst_n)
         vid_valid |=> (out_hs == ($past(vid_hs) ^ $past(cfg_hs_low))));
   end

   vsc_field_gen #(.EXTRACT(FIELD_FROM_VSYNC)) u_fld (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (vid_valid),
      .hs    (nh),
      .vs    (nv),
      .f_in  (nf),
      .f_out (out_f)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_data  <= '0;
         out_valid <= 1'b0;
         out_hs    <= 1'b0;
         out_vs    <= 1'b0;
         out_de    <= 1'b0;
      end else begin
         out_data  <= vid_data;
         out_valid <= vid_valid;
         out_de    <= vid_valid & nde;
         if (vid_valid) begin
            out_hs <= nh;
            out_vs <= nv;
         end
      end
   end

   // R1: one-cycle latency on the data path
   a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
      vid_valid |=> (out_valid && (out_data == $past(vid_data))));
   // R2: unqualified words change nothing
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !vid_valid |=> (!out_valid && !out_de && !anc_we && $stable(out_hs) &&
                      $stable(out_vs) && $stable(out_f)));
endmodule

// File: tb/vid_sync_cond_tb_top.sv
`timescale 1ns/1ps
module vid_sync_cond_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // stimulus
   logic       e_valid = 1'b0;
   logic [9:0] e_data  = '0;
   logic       s_valid = 1'b0, s_hs = 1'b0, s_vs = 1'b0, s_de = 1'b0, s_fld = 1'b0;
   logic [9:0] s_data  = '0;
   logic       cfg_h = 1'b0, cfg_v = 1'b0;

   // embedded DUT outputs
   logic [9:0] eo_data, eo_wdata;
   logic       eo_valid, eo_hs, eo_vs, eo_de, eo_f, eo_we;
   logic [3:0] eo_addr;
   // discrete, edge-derived field
   logic [9:0] xo_data, unused_xw;
   logic       xo_valid, xo_hs, xo_vs, xo_de, xo_f, unused_xwe;
   logic [3:0] unused_xa;
   // discrete, pin field
   logic [9:0] po_data, unused_pw;
   logic       po_valid, po_hs, po_vs, po_de, po_f, unused_pwe;
   logic [3:0] unused_pa;

   vid_sync_cond #(.DATA_W(10), .EMBEDDED(1'b1), .FIELD_FROM_VSYNC(1'b0), .ANC_DEPTH(16)) dut_i (
      .clk(clk), .rst_n(rst_n), .vid_data(e_data), .vid_valid(e_valid),
      .vid_hs(1'b0), .vid_vs(1'b0), .vid_de(1'b0), .vid_fld(1'b0),
      .cfg_hs_low(1'b0), .cfg_vs_low(1'b0),
      .out_data(eo_data), .out_valid(eo_valid), .out_hs(eo_hs), .out_vs(eo_vs),
      .out_de(eo_de), .out_f(eo_f), .anc_we(eo_we), .anc_addr(eo_addr), .anc_wdata(eo_wdata));

   vid_sync_cond #(.DATA_W(10), .EMBEDDED(1'b0), .FIELD_FROM_VSYNC(1'b1), .ANC_DEPTH(16)) dut_sep_i (
      .clk(clk), .rst_n(rst_n), .vid_data(s_data), .vid_valid(s_valid),
      .vid_hs(s_hs), .vid_vs(s_vs), .vid_de(s_de), .vid_fld(s_fld),
      .cfg_hs_low(cfg_h), .cfg_vs_low(cfg_v),
      .out_data(xo_data), .out_valid(xo_valid), .out_hs(xo_hs), .out_vs(xo_vs),
      .out_de(xo_de), .out_f(xo_f), .anc_we(unused_xwe), .anc_addr(unused_xa), .anc_wdata(unused_xw));

   vid_sync_cond #(.DATA_W(10), .EMBEDDED(1'b0), .FIELD_FROM_VSYNC(1'b0), .ANC_DEPTH(16)) dut_pin_i (
      .clk(clk), .rst_n(rst_n), .vid_data(s_data), .vid_valid(s_valid),
      .vid_hs(s_hs), .vid_vs(s_vs), .vid_de(s_de), .vid_fld(s_fld),
      .cfg_hs_low(cfg_h), .cfg_vs_low(cfg_v),
      .out_data(po_data), .out_valid(po_valid), .out_hs(po_hs), .out_vs(po_vs),
      .out_de(po_de), .out_f(po_f), .anc_we(unused_pwe), .anc_addr(unused_pa), .anc_wdata(unused_pw));

   // reference state: embedded
   logic [9:0] m0 = '0, m1 = '0, m2 = '0;
   bit   eH = 1'b1, eV = 1'b1, eF = 1'b0;
   int   ast = 0, ahc = 0, arem = 0, aptr = 0;
   bit   ex_valid = 0, ex_hs = 0, ex_vs = 0, ex_de = 0, ex_f = 0, ex_we = 0, ex_blank = 0;
   logic [9:0] ex_data = '0, ex_wd = '0;
   int   ex_addr = 0;
   // reference state: discrete
   bit   vprev = 0, sx_valid = 0, sx_hs = 0, sx_vs = 0, sx_de = 0, sx_fx = 0, sx_fp = 0;
   logic [9:0] sx_data = '0;

   function automatic logic [9:0] code_word(input bit f, input bit v, input bit h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
   endfunction

   function automatic logic [9:0] pix_word();
      return 10'(4 + $urandom_range(0, 1015));
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input bit ev, input logic [9:0] ew);
      bit xyz;
      s_valid = ($urandom_range(0, 3) != 0);
      s_hs    = 1'($urandom_range(0, 1));
      s_vs    = 1'($urandom_range(0, 1));
      s_de    = 1'($urandom_range(0, 1));
      s_fld   = 1'($urandom_range(0, 1));
      s_data  = 10'($urandom);
      e_valid = ev;
      e_data  = ew;
      // embedded model
      ex_data  = ew;
      ex_valid = ev;
      ex_we    = 1'b0;
      if (ev) begin
         ex_blank = eH | eV;
         xyz = (m2 == 10'h3FF) && (m1 == 10'h000) && (m0 == 10'h000);
         if (xyz) begin eF = ew[8]; eV = ew[7]; eH = ew[6]; end
         ex_de = !xyz && (ew != 10'h000) && (ew != 10'h3FF) && !eH && !eV;
         ex_hs = eH; ex_vs = eV; ex_f = eF;
         case (ast)
            0: if (ex_blank && ew == 10'h3FF && m0 == 10'h3FF && m1 == 10'h000) begin
                  ast = 1; ahc = 0;
               end
            1: begin
                  ex_we = 1; ex_addr = aptr; ex_wd = ew; aptr = (aptr + 1) % 16;
                  if (ahc == 2) begin arem = int'(ew[7:0]); ast = (arem == 0) ? 0 : 2; end
                  ahc++;
               end
            default: begin
                  ex_we = 1; ex_addr = aptr; ex_wd = ew; aptr = (aptr + 1) % 16;
                  if (arem == 1) ast = 0;
                  arem--;
               end
         endcase
         m2 = m1; m1 = m0; m0 = ew;
      end else begin
         ex_de = 1'b0;
      end
      // discrete model
      sx_data  = s_data;
      sx_valid = s_valid;
      if (s_valid) begin
         sx_hs = s_hs ^ cfg_h;
         sx_vs = s_vs ^ cfg_v;
         sx_de = s_de;
         if (sx_vs && !vprev) sx_fx = sx_hs;
         vprev = sx_vs;
         sx_fp = s_fld;
      end else begin
         sx_de = 1'b0;
      end
      @(posedge clk); #1;
      // embedded checks
      chk("R1 emb out_valid", 32'(eo_valid), 32'(ex_valid));
      chk("R1 emb out_data", 32'(eo_data), 32'(ex_data));
      chk(ev ? "R3 emb out_hs" : "R2 emb out_hs hold", 32'(eo_hs), 32'(ex_hs));
      chk(ev ? "R3 emb out_vs" : "R2 emb out_vs hold", 32'(eo_vs), 32'(ex_vs));
      chk(ev ? "R4 emb out_de" : "R2 emb out_de", 32'(eo_de), 32'(ex_de));
      chk(ev ? "R7 emb out_f" : "R2 emb out_f hold", 32'(eo_f), 32'(ex_f));
      chk(ex_blank ? "R8 anc_we" : "R10 anc_we in active", 32'(eo_we), 32'(ex_we));
      if (ex_we) begin
         chk("R9 anc_addr", 32'(eo_addr), 32'(ex_addr));
         chk("R8 anc_wdata", 32'(eo_wdata), 32'(ex_wd));
      end
      // discrete checks
      chk("R1 sep out_valid", 32'(xo_valid), 32'(sx_valid));
      chk("R1 sep out_data", 32'(xo_data), 32'(sx_data));
      chk(s_valid ? "R5 sep out_hs" : "R2 sep out_hs hold", 32'(xo_hs), 32'(sx_hs));
      chk(s_valid ? "R5 sep out_vs" : "R2 sep out_vs hold", 32'(xo_vs), 32'(sx_vs));
      chk(s_valid ? "R5 sep out_de" : "R2 sep out_de", 32'(xo_de), 32'(sx_de));
      chk("R6 sep edge field", 32'(xo_f), 32'(sx_fx));
      chk("R7 sep pin field", 32'(po_f), 32'(sx_fp));
      chk("R5 pin-variant out_hs", 32'(po_hs), 32'(sx_hs));
      chk("R5 pin-variant out_vs", 32'(po_vs), 32'(sx_vs));
      chk("R1 pin-variant out_data", 32'(po_data), 32'(sx_data));
      chk("R5 pin-variant out_de", 32'(po_de), 32'(sx_de));
      chk("R1 pin-variant out_valid", 32'(po_valid), 32'(sx_valid));
   endtask

   // valid word, sometimes preceded by idle cycles carrying code-like garbage
   task automatic put(input logic [9:0] w);
      if ($urandom_range(0, 3) == 0) begin
         for (int g = 0; g < int'($urandom_range(1, 2)); g++) begin
            case ($urandom_range(0, 2))
               0:       step(1'b0, 10'h3FF);
               1:       step(1'b0, 10'h000);
               default: step(1'b0, pix_word());
            endcase
         end
      end
      step(1'b1, w);
   endtask

   task automatic put_code(input bit f, input bit v, input bit h);
      put(10'h3FF); put(10'h000); put(10'h000); put(code_word(f, v, h));
   endtask

   task automatic put_line(input bit f, input bit v, input int nact, input int anc_n, input bit start_in_active);
      put_code(f, v, 1'b1);
      repeat (3) put(pix_word());
      if (anc_n >= 0) begin
         put(10'h000); put(10'h3FF); put(10'h3FF);
         put(pix_word()); put(pix_word()); put(10'(anc_n));
         repeat (anc_n) put(pix_word());
         put(pix_word());
      end
      repeat (2) put(pix_word());
      put_code(f, v, 1'b0);
      for (int i = 0; i < nact; i++) begin
         if (start_in_active && i == 2) begin
            put(10'h000); put(10'h3FF); put(10'h3FF);
         end
         put(pix_word());
      end
   endtask

   task automatic run_lines(input int n, input int base);
      for (int i = 0; i < n; i++) begin
         int a;
         a = ((i % 2) == 0) ? int'($urandom_range(0, 10)) : -1;
         if (base == 0 && i == 0) a = 0;
         put_line(((base + i) / 4) % 2 == 1, (i % 5) < 2, 6 + int'($urandom_range(0, 10)), a,
                  (i % 4) == 3);
      end
   endtask

   initial begin
      void'($urandom(32'h5EED));
      repeat (3) @(posedge clk);
      #1;
      // R11: reset state
      chk("R11 reset out_valid", 32'(eo_valid | xo_valid | po_valid), 32'h0);
      chk("R11 reset syncs", 32'({eo_hs, eo_vs, xo_hs, xo_vs, po_hs, po_vs}), 32'h0);
      chk("R11 reset de/f", 32'({eo_de, eo_f, xo_de, xo_f, po_de, po_f}), 32'h0);
      chk("R11 reset anc", 32'({eo_we, eo_addr}), 32'h0);
      chk("R11 reset data", 32'(eo_data | xo_data | po_data), 32'h0);
      rst_n = 1'b1;
      // idle before any code: words ignored
      repeat (3) step(1'b0, 10'h3FF);
      cfg_h = 1'b0; cfg_v = 1'b0;
      run_lines(12, 0);
      cfg_h = 1'b1; cfg_v = 1'b1;
      run_lines(8, 12);
      cfg_h = 1'b1; cfg_v = 1'b0;
      run_lines(4, 20);
      cfg_h = 1'b0; cfg_v = 1'b1;
      run_lines(4, 24);
      repeat (4) step(1'b0, 10'h000);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule